// File: doc/BRIEF.md
# Pipeline Hazard and Flush Controller

This block is the hazard logic of a five-stage in-order pipeline (fetch, decode, ALU, memory, writeback). Each cycle it compares the two source registers of the instruction in decode with the destinations of the older instructions now in the ALU and memory stages. From those comparisons it decides whether the decode instruction can go ahead with its operands from the register file, whether it must take the ALU-stage result through a bypass, or whether it must wait. It also kills the two youngest instructions when a jump or taken branch resolves in the ALU stage.

The hold, kill and bypass outputs are combinational from the stage fields of the same cycle. The surrounding pipeline uses `stall` to freeze the PC and the fetch/decode latch and to send an empty slot into the ALU stage. It uses `flush` to mark the fetch and decode instructions as empty slots while fetch moves to the resolved target. Two saturating counters record how many cycles were spent holding and how many kills occurred. A producer that has reached writeback writes its register before decode reads it in the same cycle, so that stage needs no input.

Top module: `pipe_hazard_unit`

## Requirements
- R1: After reset, `stallCount` and `flushCount` are both zero.
- R2: When the valid, writing ALU-stage instruction is not a load and its destination equals a decode source, that source's bypass select (`fwdSrcA` or `fwdSrcB`) is 1 and `stall` stays 0. The value 1 means "use the ALU-stage result", and each source is judged separately.
- R3: When the valid, writing ALU-stage instruction is a load and its destination equals either decode source, `stall` is 1 and no bypass select is set for that source.
- R4: When the valid, writing memory-stage instruction's destination equals either decode source, `stall` is 1, whether that instruction is a load or not.
- R5: Register 0 never matches. An older slot with valid=0 never matches. A decode slot with valid=0 never raises `stall` or a bypass select.
- R6: An older instruction with write enable 0 never causes a stall or a bypass, even when its destination field equals a decode source. Pairs of the write-after-write or write-after-read kind cannot raise any output.
- R7: When `aRedirect` is 1, `flush` is 1 and `stall` is 0 in the same cycle, even if a data hazard is present.
- R8: `stallCount` rises by one after each clock edge at which `stall` was 1. `flushCount` rises by one after each edge at which `flush` was 1. Both hold at their all-ones value instead of wrapping.
- R9: A load followed directly by a consumer of its result costs exactly two stall cycles: one with the load in the ALU stage and one with it in the memory stage. No stall occurs once the load reaches writeback.
- R10: A producer that is two slots ahead and not a load costs exactly one stall cycle. A producer four slots ahead costs none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dValid | input | 1 | Decode slot holds a real instruction |
| dSrcA | input | REG_W | First source register of decode instruction |
| dSrcB | input | REG_W | Second source register of decode instruction |
| aValid | input | 1 | ALU slot holds a real instruction |
| aWrEn | input | 1 | ALU-stage instruction writes a register |
| aIsLoad | input | 1 | ALU-stage instruction is a load |
| aDst | input | REG_W | ALU-stage destination register |
| mValid | input | 1 | Memory slot holds a real instruction |
| mWrEn | input | 1 | Memory-stage instruction writes a register |
| mDst | input | REG_W | Memory-stage destination register |
| aRedirect | input | 1 | Jump or taken branch resolving in the ALU stage |
| stall | output | 1 | Hold PC and fetch/decode latch, empty slot into ALU |
| flush | output | 1 | Turn fetch and decode instructions into empty slots |
| fwdSrcA | output | 1 | First source takes the ALU-stage result |
| fwdSrcB | output | 1 | Second source takes the ALU-stage result |
| stallCount | output | CNT_W | Saturating count of stall cycles |
| flushCount | output | CNT_W | Saturating count of flush cycles |

## Verification
The bench builds the block with REG_W=5 and CNT_W=4. With a 4-bit counter, the hold-at-all-ones behaviour of R8 is reached after fifteen stall cycles, well within a short directed test. The five-bit register field keeps register 0 and distinct high-numbered registers available, so the match, no-match and register-0 cases of R5 can all be driven. The hazard sequences are replayed stage by stage, so the stall cycle counts of R9 and R10 show up in both the combinational outputs and the counters.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;
  localparam int NUM_SRC = 2;

  typedef struct packed {
    logic               stall;
    logic               flush;
    logic [NUM_SRC-1:0] fwd;
  } hazStrobe_t;
endpackage

// File: rtl/pipe_hazard_datapath.sv
module pipe_hazard_datapath
  import pipe_hazard_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dValid,
  input  logic [NUM_SRC-1:0][REG_W-1:0] dSrc,
  input  logic                          aValid,
  input  logic                          aWrEn,
  input  logic [REG_W-1:0]              aDst,
  input  logic                          mValid,
  input  logic                          mWrEn,
  input  logic [REG_W-1:0]              mDst,
  input  hazStrobe_t                    strobe,
  output logic [NUM_SRC-1:0]            hitAlu,
  output logic [NUM_SRC-1:0]            hitMem,
  output logic [CNT_W-1:0]              stallCount,
  output logic [CNT_W-1:0]              flushCount
);
  localparam int NUM_EVT = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // a producer only counts when it really writes a nonzero register
  logic aWrites, mWrites;
  assign aWrites = aValid && aWrEn && (aDst != '0);
  assign mWrites = mValid && mWrEn && (mDst != '0);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
    assign hitAlu[s] = dValid && aWrites && (dSrc[s] == aDst);
    assign hitMem[s] = dValid && mWrites && (dSrc[s] == mDst);
  end

  logic [NUM_EVT-1:0]            evt;
  logic [NUM_EVT-1:0][CNT_W-1:0] cnt;
  assign evt = {strobe.flush, strobe.stall};

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt[e] <= '0;
      else if (evt[e] && cnt[e] != CNT_MAX) cnt[e] <= cnt[e] + 1'b1;
    end
  end

  assign stallCount = cnt[0];
  assign flushCount = cnt[1];
endmodule

// File: rtl/pipe_hazard_control.sv
module pipe_hazard_control
  import pipe_hazard_pkg::*;
(
  input  logic               aIsLoad,
  input  logic               aRedirect,
  input  logic [NUM_SRC-1:0] hitAlu,
  input  logic [NUM_SRC-1:0] hitMem,
  output hazStrobe_t         strobe
);
  logic needWait;

  always_comb begin
    // load result is not ready until it leaves memory; any memory-stage match waits too
    needWait     = (|hitMem) || (aIsLoad && (|hitAlu));
    strobe.flush = aRedirect;
    strobe.stall = needWait && !aRedirect;
    strobe.fwd   = aIsLoad ? '0 : hitAlu;
  end
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import pipe_hazard_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dValid,
  input  logic [REG_W-1:0] dSrcA,
  input  logic [REG_W-1:0] dSrcB,
  input  logic             aValid,
  input  logic             aWrEn,
  input  logic             aIsLoad,
  input  logic [REG_W-1:0] aDst,
  input  logic             mValid,
  input  logic             mWrEn,
  input  logic [REG_W-1:0] mDst,
  input  logic             aRedirect,
  output logic             stall,
  output logic             flush,
  output logic             fwdSrcA,
  output logic             fwdSrcB,
  output logic [CNT_W-1:0] stallCount,
  output logic [CNT_W-1:0] flushCount
);
  hazStrobe_t         strobe;
  logic [NUM_SRC-1:0] hitAlu, hitMem;
  logic [NUM_SRC-1:0][REG_W-1:0] dSrc;

  assign dSrc = {dSrcB, dSrcA};

  pipe_hazard_datapath #(.REG_W(REG_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .dValid(dValid), .dSrc(dSrc),
    .aValid(aValid), .aWrEn(aWrEn), .aDst(aDst),
    .mValid(mValid), .mWrEn(mWrEn), .mDst(mDst),
    .strobe(strobe), .hitAlu(hitAlu), .hitMem(hitMem),
    .stallCount(stallCount), .flushCount(flushCount)
  );

  pipe_hazard_control u_ctl (
    .aIsLoad(aIsLoad), .aRedirect(aRedirect),
    .hitAlu(hitAlu), .hitMem(hitMem), .strobe(strobe)
  );

  assign stall   = strobe.stall;
  assign flush   = strobe.flush;
  assign fwdSrcA = strobe.fwd[0];
  assign fwdSrcB = strobe.fwd[1];
endmodule

// File: rtl/pipe_hazard_checker.sv
module pipe_hazard_checker #(
  parameter int REG_W = 5,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dValid,
  input logic [REG_W-1:0] dSrcA,
  input logic [REG_W-1:0] dSrcB,
  input logic             aValid,
  input logic             aWrEn,
  input logic             aIsLoad,
  input logic [REG_W-1:0] aDst,
  input logic             mValid,
  input logic             mWrEn,
  input logic [REG_W-1:0] mDst,
  input logic             aRedirect,
  input logic             stall,
  input logic             flush,
  input logic             fwdSrcA,
  input logic             fwdSrcB,
  input logic [CNT_W-1:0] stallCount,
  input logic [CNT_W-1:0] flushCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_redirect_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    aRedirect |-> (flush && !stall));

  assert_load_match_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dValid && aValid && aWrEn && aIsLoad && aDst != '0 && aDst == dSrcA && !aRedirect)
      |-> (stall && !fwdSrcA));

  assert_mem_match_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dValid && mValid && mWrEn && mDst != '0 && mDst == dSrcB && !aRedirect) |-> stall);

  assert_reg_zero_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dSrcA == '0) |-> !fwdSrcA);

  assert_no_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!aWrEn && !mWrEn) |-> (!stall && !fwdSrcA && !fwdSrcB));

  assert_stall_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && stallCount != CNT_MAX) |=> (stallCount == $past(stallCount) + 1'b1));

  assert_stall_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> $stable(stallCount));

  assert_flush_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> $stable(flushCount));
endmodule

bind pipe_hazard_unit pipe_hazard_checker #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_pipe_hazard_unit.sv
module test_pipe_hazard_unit;
  localparam int REG_W = 5;
  localparam int CNT_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dValid, aValid, aWrEn, aIsLoad, mValid, mWrEn, aRedirect;
  logic [REG_W-1:0] dSrcA, dSrcB, aDst, mDst;
  logic stall, flush, fwdSrcA, fwdSrcB;
  logic [CNT_W-1:0] stallCount, flushCount;

  int checks = 0, errors = 0;
  int expStalls = 0, expFlushes = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pipe_hazard_unit #(.REG_W(REG_W), .CNT_W(CNT_W)) i_pipe_hazard_unit (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    dValid = 1'b0; dSrcA = '0; dSrcB = '0;
    aValid = 1'b0; aWrEn = 1'b0; aIsLoad = 1'b0; aDst = '0;
    mValid = 1'b0; mWrEn = 1'b0; mDst = '0; aRedirect = 1'b0;
  endtask

  task automatic setDec(input logic [REG_W-1:0] a, input logic [REG_W-1:0] b);
    dValid = 1'b1; dSrcA = a; dSrcB = b;
  endtask

  task automatic setAlu(input logic v, input logic we, input logic ld, input logic [REG_W-1:0] d);
    aValid = v; aWrEn = we; aIsLoad = ld; aDst = d;
  endtask

  task automatic setMem(input logic v, input logic we, input logic [REG_W-1:0] d);
    mValid = v; mWrEn = we; mDst = d;
  endtask

  // outputs settle after inputs change at the falling edge
  task automatic expectOut(input string req, input int st, input int fl, input int fa, input int fb);
    #1;
    check({req, " stall"}, stall, st);
    check({req, " flush"}, flush, fl);
    check({req, " fwdA"}, fwdSrcA, fa);
    check({req, " fwdB"}, fwdSrcB, fb);
  endtask

  // clock one edge; counters are compared half a cycle later
  task automatic step(input int st, input int fl);
    @(posedge clk);
    if (st != 0 && expStalls < 15) expStalls++;
    if (fl != 0 && expFlushes < 15) expFlushes++;
    @(negedge clk);
    check("R8 stallCount", stallCount, expStalls);
    check("R8 flushCount", flushCount, expFlushes);
  endtask

  task automatic testReset();
    check("R1 stallCount", stallCount, 0);
    check("R1 flushCount", flushCount, 0);
  endtask

  task automatic testBypass();
    idle(); setDec(5'd3, 5'd9); setAlu(1, 1, 0, 5'd3);
    expectOut("R2 srcA", 0, 0, 1, 0);
    step(0, 0);
    idle(); setDec(5'd4, 5'd7); setAlu(1, 1, 0, 5'd7);
    expectOut("R2 srcB", 0, 0, 0, 1);
    step(0, 0);
    idle(); setDec(5'd6, 5'd6); setAlu(1, 1, 0, 5'd6);
    expectOut("R2 both", 0, 0, 1, 1);
    step(0, 0);
  endtask

  task automatic testLoadUse();
    idle(); setDec(5'd8, 5'd5); setAlu(1, 1, 1, 5'd5);
    expectOut("R3 R9 load in ALU", 1, 0, 0, 0);
    step(1, 0);
    idle(); setDec(5'd8, 5'd5); setMem(1, 1, 5'd5);
    expectOut("R9 load in MEM", 1, 0, 0, 0);
    step(1, 0);
    idle(); setDec(5'd8, 5'd5);
    expectOut("R9 load in WB", 0, 0, 0, 0);
    step(0, 0);
  endtask

  task automatic testDistance();
    idle(); setDec(5'd12, 5'd2); setAlu(1, 1, 0, 5'd20); setMem(1, 1, 5'd12);
    expectOut("R4 R10 dist two", 1, 0, 0, 0);
    step(1, 0);
    idle(); setDec(5'd12, 5'd2); setMem(1, 1, 5'd20);
    expectOut("R10 dist two released", 0, 0, 0, 0);
    step(0, 0);
    idle(); setDec(5'd12, 5'd2); setAlu(1, 1, 0, 5'd21); setMem(1, 1, 5'd22);
    expectOut("R10 dist four", 0, 0, 0, 0);
    step(0, 0);
  endtask

  task automatic testQuiet();
    idle(); setDec(5'd0, 5'd0); setAlu(1, 1, 1, 5'd0); setMem(1, 1, 5'd0);
    expectOut("R5 reg zero", 0, 0, 0, 0);
    step(0, 0);
    idle(); setDec(5'd11, 5'd11); setAlu(0, 1, 1, 5'd11); setMem(0, 1, 5'd11);
    expectOut("R5 older bubble", 0, 0, 0, 0);
    step(0, 0);
    idle(); setAlu(1, 1, 1, 5'd11); setMem(1, 1, 5'd11); dSrcA = 5'd11;
    expectOut("R5 decode bubble", 0, 0, 0, 0);
    step(0, 0);
    idle(); setDec(5'd13, 5'd14); setAlu(1, 0, 1, 5'd13); setMem(1, 0, 5'd14);
    expectOut("R6 no write", 0, 0, 0, 0);
    step(0, 0);
  endtask

  task automatic testFlush();
    idle(); setDec(5'd5, 5'd1); setAlu(1, 1, 1, 5'd5); aRedirect = 1'b1;
    expectOut("R7 flush beats load stall", 1'b0, 1, 0, 0);
    step(0, 1);
    idle(); aRedirect = 1'b1; setAlu(1, 0, 0, 5'd0);
    expectOut("R7 plain jump", 0, 1, 0, 0);
    step(0, 1);
  endtask

  task automatic testSaturate();
    idle(); setDec(5'd9, 5'd0); setMem(1, 1, 5'd9);
    for (int i = 0; i < 16; i++) step(1, 0);
    check("R8 stall saturates", stallCount, 15);
    idle();
    step(0, 0);
    check("R8 held at max", stallCount, 15);
  endtask

  initial begin
    idle();
    #35;
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testBypass();
    testLoadUse();
    testDistance();
    testQuiet();
    testFlush();
    testSaturate();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule